// File: doc/BRIEF.md
# Per-Channel Loss-of-Signal Monitor

This block watches two digital presence indications for every channel: one for the input signal and one for the excitation. It flags a channel as lost only after that channel's presence has been missing without a break for a long qualification window, nominally two seconds. The two results are kept apart, in a signal status word and an excitation status word. In each word bit n belongs to channel n, and a 1 means present. Analog amplitude detection is not part of the block. An upstream detector supplies each presence indication as a synchronous digital bit.

A free-running time-base pulse (`tick_i`) feeds a prescaler. The prescaler makes one sample strobe for every `TICK_DIV` pulses. On each strobe, every channel's presence bits are sampled. For each channel and each quantity, a counter counts the consecutive absent samples. The status bit drops to 0 when that count reaches `QUAL_TICKS`, and it returns to 1 on the first sample that shows presence again. A host reads the two status words through a plain read port that has one cycle of latency. That port is a simple control/status access, so it has no back-pressure: every read request is accepted and answered on the following cycle.

Top module: `los_monitor`

## Requirements
- R1: While reset is asserted and directly after it, both status words read 0 and `rd_valid_o` is 0.
- R2: A sample strobe is produced once for every `TICK_DIV` pulses of `tick_i`. Presence changes between strobes have no effect on either status word.
- R3: A channel's status bit becomes 1 on the first sample that sees its presence input at 1.
- R4: A status bit at 1 goes to 0 on the `QUAL_TICKS`-th consecutive sample with presence at 0, and not earlier.
- R5: A sample with presence at 1 restarts that channel's absence count, so a later loss needs a further `QUAL_TICKS` consecutive absent samples.
- R6: Excitation is qualified by the same rules as signal, with its own counter per channel. Signal presence never affects an excitation bit, and excitation presence never affects a signal bit.
- R7: A read with `rd_en_i` = 1 returns its data on `rd_data_o` one cycle later, with `rd_valid_o` = 1. Byte address 18h (19h is an alias, since address bit 0 is ignored) selects the signal word, and 1Ah/1Bh selects the excitation word. Bit n of each word is channel n.
- R8: Status bits `NUM_CH` to 15 always read 0, and a read of any other address returns 0.
- R9: After reset, a bit stays 0 through any number of absent samples until presence is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base pulse, one cycle wide, into the prescaler |
| sig_present_i | input | NUM_CH | Signal presence for each channel, 1 = present |
| exc_present_i | input | NUM_CH | Excitation presence for each channel, 1 = present |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 8 | Byte address of the read |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| rd_data_o | output | 16 | Read data |

## Verification
A status bit changes two clocks after the `tick_i` pulse that completes a prescaler group: one clock for the strobe register and one for the status register. Read data follows a request by one clock. The bench drives every input on the falling edge. It completes each group of `TICK_DIV` pulses and then waits two further falling edges before it issues a read, and it samples `rd_data_o` on the falling edge after the request. Its model therefore advances exactly once per group and is compared against a settled register.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;
  // Word addresses (byte address with bit 0 dropped)
  localparam logic [ADDR_W-2:0] SIG_WORD = 7'h0C; // 18h/19h
  localparam logic [ADDR_W-2:0] EXC_WORD = 7'h0D; // 1Ah/1Bh

  typedef enum logic [1:0] {
    SEL_SIG  = 2'd0,
    SEL_EXC  = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/los_prescaler.sv
module los_prescaler #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic samp_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      samp_o <= 1'b0;
    end else begin
      samp_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          samp_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2
  samp_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |-> $past(tick_i));
endmodule

// File: rtl/los_qualifier.sv
module los_qualifier #(
  parameter int QUAL_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic samp_i,
  input  logic present_i,
  output logic stat_o
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(QUAL_TICKS - 1);

  logic [CW-1:0] miss_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      miss_q <= '0;
      stat_o <= 1'b0;
    end else if (samp_i) begin
      if (present_i) begin
        miss_q <= '0;
        stat_o <= 1'b1;
      end else if (miss_q == LIM) begin
        stat_o <= 1'b0;
      end else begin
        miss_q <= miss_q + 1'b1;
      end
    end
  end

  // R3
  recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_i && present_i) |=> stat_o);
  // R4
  no_early_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && samp_i && !present_i && miss_q < LIM) |=> stat_o);
  // R4
  loss_on_absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o) |-> $past(samp_i && !present_i));
  // R2
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_i |=> $stable(stat_o));
endmodule

// File: rtl/los_regread.sv
module los_regread
  import los_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    sig_stat_i,
  input  logic [NUM_CH-1:0]    exc_stat_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic                 rd_valid_o,
  output logic [REG_W-1:0]     rd_data_o
);
  logic [REG_W-1:0] sig_word, exc_word;
  reg_sel_e         sel;

  generate
    if (NUM_CH == REG_W) begin : g_full
      assign sig_word = sig_stat_i;
      assign exc_word = exc_stat_i;
    end else begin : g_pad
      assign sig_word = {{(REG_W-NUM_CH){1'b0}}, sig_stat_i};
      assign exc_word = {{(REG_W-NUM_CH){1'b0}}, exc_stat_i};
    end
  endgenerate

  always_comb begin
    if (rd_addr_i[ADDR_W-1:1] == SIG_WORD)      sel = SEL_SIG;
    else if (rd_addr_i[ADDR_W-1:1] == EXC_WORD) sel = SEL_EXC;
    else                                        sel = SEL_NONE;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        case (sel)
          SEL_SIG: rd_data_o <= sig_word;
          SEL_EXC: rd_data_o <= exc_word;
          default: rd_data_o <= '0;
        endcase
      end
    end
  end

  // R7
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  // R7
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i[ADDR_W-1:1] != SIG_WORD && rd_addr_i[ADDR_W-1:1] != EXC_WORD)
    |=> (rd_data_o == '0));
endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int NUM_CH     = 12,
  parameter int TICK_DIV   = 1000,
  parameter int QUAL_TICKS = 2000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [NUM_CH-1:0]    sig_present_i,
  input  logic [NUM_CH-1:0]    exc_present_i,
  input  logic                 rd_en_i,
  input  logic [7:0]           rd_addr_i,
  output logic                 rd_valid_o,
  output logic [15:0]          rd_data_o
);
  logic              samp;
  logic [NUM_CH-1:0] sig_stat, exc_stat;

  los_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .samp_o (samp)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    los_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_sig (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .samp_i    (samp),
      .present_i (sig_present_i[c]),
      .stat_o    (sig_stat[c])
    );
    los_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_exc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .samp_i    (samp),
      .present_i (exc_present_i[c]),
      .stat_o    (exc_stat[c])
    );
  end

  los_regread #(.NUM_CH(NUM_CH)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_stat_i (sig_stat),
    .exc_stat_i (exc_stat),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (rd_valid_o == 1'b0 && rd_data_o == '0));

  if (NUM_CH < REG_W) begin : g_pad_chk
    // R8
    pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |-> (rd_data_o[REG_W-1:NUM_CH] == '0));
  end
endmodule

// File: tb/test_los_monitor.sv
module test_los_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 12;
  localparam int DIV  = 3;
  localparam int QUAL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [NCH-1:0] sp = '0, ep = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic rd_valid;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int  scnt [NCH];
  int  ecnt [NCH];
  bit  sst  [NCH];
  bit  est  [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  los_monitor #(.NUM_CH(NCH), .TICK_DIV(DIV), .QUAL_TICKS(QUAL)) i_los_monitor (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .sig_present_i(sp), .exc_present_i(ep),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic bit qual_next_st(bit st, int cnt, bit pres);
    if (pres) return 1'b1;
    if (cnt == QUAL - 1) return 1'b0;
    return st;
  endfunction

  function automatic int qual_next_cnt(int cnt, bit pres);
    if (pres) return 0;
    if (cnt == QUAL - 1) return cnt;
    return cnt + 1;
  endfunction

  function automatic logic [15:0] exp_word(logic [7:0] a);
    logic [15:0] w = '0;
    for (int c = 0; c < NCH; c++) begin
      if (a[7:1] == 7'h0C) w[c] = sst[c];
      else if (a[7:1] == 7'h0D) w[c] = est[c];
    end
    return w;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one full prescaler group, then let the status register settle
  task automatic step();
    for (int i = 0; i < DIV; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      sst[c]  = qual_next_st(sst[c], scnt[c], sp[c]);
      scnt[c] = qual_next_cnt(scnt[c], sp[c]);
      est[c]  = qual_next_st(est[c], ecnt[c], ep[c]);
      ecnt[c] = qual_next_cnt(ecnt[c], ep[c]);
    end
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    rd_en = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " valid"}, {15'd0, rd_valid}, 16'd1);
    chk(req, rd_data, exp_word(a));
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      scnt[c] = 0; ecnt[c] = 0; sst[c] = 0; est[c] = 0;
    end
    void'($urandom(32'h0051_6E4A));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid at reset", {15'd0, rd_valid}, 16'd0);
    chk("R1 data at reset", rd_data, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 sig after reset", 8'h18);
    rd_chk("R1 exc after reset", 8'h1A);

    // R9: absent for long stays 0
    repeat (QUAL + 2) step();
    rd_chk("R9 sig stays 0", 8'h18);
    rd_chk("R9 exc stays 0", 8'h1A);

    // R2: presence glitch between strobes ignored
    @(negedge clk) sp = '1; ep = '1;
    repeat (4) @(negedge clk);
    sp = '0; ep = '0;
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    rd_chk("R2 glitch ignored sig", 8'h18);
    rd_chk("R2 glitch ignored exc", 8'h1B);
    // complete that group (one tick already sent)
    for (int i = 1; i < DIV; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      scnt[c] = qual_next_cnt(scnt[c], 1'b0);
      ecnt[c] = qual_next_cnt(ecnt[c], 1'b0);
    end
    rd_chk("R2 group with absent sample", 8'h18);

    // R3 / R6: signal present only on ch0, exc only on ch1
    sp = 12'h001; ep = 12'h002;
    step();
    rd_chk("R3 sig ch0 up", 8'h18);
    rd_chk("R6 exc ch1 up independent", 8'h1A);

    // R4: loss only on QUAL-th absent sample
    sp = '0; ep = '0;
    repeat (QUAL - 1) step();
    rd_chk("R4 sig not yet lost", 8'h18);
    rd_chk("R4 exc not yet lost", 8'h1A);
    step();
    rd_chk("R4 sig lost", 8'h19);
    rd_chk("R4 exc lost", 8'h1B);

    // R5: present sample restarts the count
    sp = 12'h0F0; ep = 12'h0F0;
    step();
    sp = '0; ep = '0;
    repeat (QUAL - 1) step();
    sp = 12'h0F0; ep = 12'h0F0;
    step();
    sp = '0; ep = '0;
    repeat (QUAL - 1) step();
    rd_chk("R5 sig count restarted", 8'h18);
    rd_chk("R5 exc count restarted", 8'h1A);

    // R8: unused bits and unmapped addresses
    sp = '1; ep = '1;
    step();
    rd_chk("R8 sig pad bits zero", 8'h18);
    rd_chk("R8 exc pad bits zero", 8'h1A);
    rd_chk("R8 unmapped 10h", 8'h10);
    rd_chk("R8 unmapped 1Ch", 8'h1C);
    rd_chk("R7 sig alias 19h", 8'h19);

    // random phase (R3 R4 R5 R6 R7)
    for (int n = 0; n < 200; n++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(0, 4) == 0) sp[c] = ~sp[c];
        if ($urandom_range(0, 4) == 0) ep[c] = ~ep[c];
      end
      step();
      rd_chk("R4 random sig", 8'h18);
      rd_chk("R6 random exc", 8'h1A);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule